// File: doc/BRIEF.md
# Rotational Position and Index Marker Tracker

This block keeps the angular position of a head-per-track disk as a free-running word counter. A programmable interval sets how many clock cycles one word takes to pass under the heads. The counter steps once per interval and wraps after 2048 words, which is one revolution. The timing model assumes 128 tracks on each surface and four surfaces per controller. Only the angle is modelled here, so the same position applies to every track. No data moves through this block.

Four results are derived from the position. An index marker is high for the first few word slots of each revolution. An address-match flag is high when the low address bits of a requested word equal the current position. A registered latency gives the number of word times until the requested word arrives, counted forward modulo one revolution. When its enable is set, a one-cycle interrupt pulse fires once per revolution at the index. A controller uses the latency to schedule a transfer and the match flag to skip-test a position.

Top module: `rot_pos_tracker`

## Requirements
- R1: After position 2047 the next advance gives position 0. A full revolution is therefore 2048 advances.
- R2: The position starts at 0 after reset. It advances by exactly one after every N clock cycles, where N is the value on `word_ivl_i` (1 to 65535), and holds its value in between.
- R3: An interval of 0 behaves exactly like an interval of 1, so the position advances on every cycle.
- R4: `index_mark_o` is high exactly when the current position is below 6, that is word slots 0 to 5.
- R5: `addr_hit_o` is high in the same cycle in which `tgt_word_i` equals the current position.
- R6: `latency_o` in cycle t+1 equals (`tgt_word_i` − position) mod 2048, using the values in cycle t.
- R7: When the target is behind the position, the latency is target − position + 2048. For example, target 3 at position 10 gives 2041.
- R8: When `mark_irq_en_i` is high in the cycle that advances the position from 2047, `mark_irq_o` is high for exactly one cycle. That cycle is the first one at position 0. The pulse comes once per revolution.
- R9: When `mark_irq_en_i` is low in the wrapping cycle, no pulse is produced.
- R10: While `rst_ni` is low, the position, the latency and the pulse are 0 and the interval timer is cleared. Reset acts asynchronously.
- R11: When the interval is lowered below the number of cycles already spent on the current word, the position advances on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_ivl_i | input | 16 | Clock cycles per word; 0 acts as 1 |
| tgt_word_i | input | 11 | Requested word position within a revolution |
| mark_irq_en_i | input | 1 | Enables the once-per-revolution index pulse |
| pos_o | output | 11 | Current angular position in words |
| index_mark_o | output | 1 | High while the position is inside the index window |
| addr_hit_o | output | 1 | Target equals the current position |
| latency_o | output | 11 | Word times from the position to the target, registered |
| mark_irq_o | output | 1 | One-cycle index interrupt pulse |

## Verification
The bench uses the default parameters: an 11-bit position, a 16-bit interval and a six-slot index window. This keeps the wrap at its real size of 2048 words. With an interval of 1, one revolution takes 2048 cycles, so the bench can cover several wraps, interrupt pulses with the enable both on and off, and a full sweep of the index window well within its run length. It also uses the zero interval, an interval of 5 with targets both ahead of and behind the position, and a sudden drop from a long interval to a short one.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

  // Last count value of the word timer; a zero interval acts as one cycle.
  function automatic int unsigned interval_last(input int unsigned ivl);
    return (ivl == 0) ? 0 : ivl - 1;
  endfunction

  // Forward distance on a ring of 'words' slots (power of two).
  function automatic int unsigned ring_gap(input int unsigned to_w,
                                           input int unsigned from_w,
                                           input int unsigned words);
    return (to_w + words - from_w) & (words - 1);
  endfunction

  // Position inside the index window.
  function automatic logic in_window(input int unsigned pos,
                                     input int unsigned width);
    return pos < width;
  endfunction

endpackage

// File: rtl/rpt_word_timer.sv
module rpt_word_timer #(
  parameter int unsigned IVL_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IVL_W-1:0] ivl_i,
  output logic             tick_o
);
  logic [IVL_W-1:0] cnt_q;
  logic [IVL_W-1:0] last_c;

  assign last_c = IVL_W'(rpt_pkg::interval_last(32'(ivl_i)));
  // Using >= lets a lowered interval end the current word at once.
  assign tick_o = (cnt_q >= last_c);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else cnt_q <= cnt_q + IVL_W'(1);
  end
endmodule

// File: rtl/rpt_pos_counter.sv
module rpt_pos_counter #(
  parameter int unsigned POS_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [POS_W-1:0] pos_o,
  output logic             at_last_o
);
  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else if (tick_i) pos_q <= pos_q + POS_W'(1);
  end

  assign pos_o     = pos_q;
  assign at_last_o = (pos_q == {POS_W{1'b1}});
endmodule

// File: rtl/rpt_latency_reg.sv
module rpt_latency_reg #(
  parameter int unsigned POS_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [POS_W-1:0] tgt_i,
  input  logic [POS_W-1:0] pos_i,
  output logic [POS_W-1:0] lat_o,
  output logic             hit_o
);
  localparam int unsigned WORDS = 1 << POS_W;
  logic [POS_W-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= '0;
    else lat_q <= POS_W'(rpt_pkg::ring_gap(32'(tgt_i), 32'(pos_i), WORDS));
  end

  assign lat_o = lat_q;
  assign hit_o = (tgt_i == pos_i);
endmodule

// File: rtl/rpt_marker_gen.sv
module rpt_marker_gen #(
  parameter int unsigned POS_W    = 11,
  parameter int unsigned MARK_WIN = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [POS_W-1:0] pos_i,
  input  logic             tick_i,
  input  logic             at_last_i,
  input  logic             irq_en_i,
  output logic             mark_o,
  output logic             irq_o
);
  logic irq_q;
  logic wrap_c;

  generate
    if (MARK_WIN == 0) begin : g_no_window
      assign mark_o = 1'b0;
    end else begin : g_window
      assign mark_o = rpt_pkg::in_window(32'(pos_i), MARK_WIN);
    end
  endgenerate

  assign wrap_c = tick_i & at_last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else irq_q <= wrap_c & irq_en_i;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/rot_pos_tracker.sv
module rot_pos_tracker #(
  parameter int unsigned POS_W    = 11,
  parameter int unsigned IVL_W    = 16,
  parameter int unsigned MARK_WIN = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IVL_W-1:0] word_ivl_i,
  input  logic [POS_W-1:0] tgt_word_i,
  input  logic             mark_irq_en_i,
  output logic [POS_W-1:0] pos_o,
  output logic             index_mark_o,
  output logic             addr_hit_o,
  output logic [POS_W-1:0] latency_o,
  output logic             mark_irq_o
);
  logic             adv_tick;
  logic             pos_at_last;
  logic [POS_W-1:0] pos_w;

  rpt_word_timer #(.IVL_W(IVL_W)) u_timer (
    .clk_i (clk_i), .rst_ni(rst_ni), .ivl_i(word_ivl_i), .tick_o(adv_tick)
  );

  rpt_pos_counter #(.POS_W(POS_W)) u_pos (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(adv_tick),
    .pos_o(pos_w), .at_last_o(pos_at_last)
  );

  rpt_latency_reg #(.POS_W(POS_W)) u_lat (
    .clk_i(clk_i), .rst_ni(rst_ni), .tgt_i(tgt_word_i), .pos_i(pos_w),
    .lat_o(latency_o), .hit_o(addr_hit_o)
  );

  rpt_marker_gen #(.POS_W(POS_W), .MARK_WIN(MARK_WIN)) u_mark (
    .clk_i(clk_i), .rst_ni(rst_ni), .pos_i(pos_w), .tick_i(adv_tick),
    .at_last_i(pos_at_last), .irq_en_i(mark_irq_en_i),
    .mark_o(index_mark_o), .irq_o(mark_irq_o)
  );

  assign pos_o = pos_w;
endmodule

// File: rtl/rot_pos_tracker_chk.sv
module rot_pos_tracker_chk #(
  parameter int unsigned POS_W    = 11,
  parameter int unsigned MARK_WIN = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick,
  input logic [POS_W-1:0] pos,
  input logic [POS_W-1:0] tgt,
  input logic [POS_W-1:0] lat,
  input logic             mark,
  input logic             hit,
  input logic             irq,
  input logic             irq_en
);
  localparam logic [POS_W-1:0] LAST = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] WIN_END = POS_W'(MARK_WIN);

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> pos == $past(pos) + POS_W'(1));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(pos));
  a_r1_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && pos == LAST) |=> pos == '0);
  a_r4_mark_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mark) |-> pos == '0);
  a_r4_mark_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mark) |-> pos == WIN_END);
  a_r5_hit_zero_lat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> lat == '0);
  a_r6_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> lat == $past(tgt) - $past(pos));
  a_r8_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq |=> !irq);
  a_r8_irq_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq |-> pos == '0);
  a_r9_no_irq_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en |=> !irq);
endmodule

bind rot_pos_tracker rot_pos_tracker_chk #(.POS_W(POS_W), .MARK_WIN(MARK_WIN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick(adv_tick), .pos(pos_w),
  .tgt(tgt_word_i), .lat(latency_o), .mark(index_mark_o),
  .hit(addr_hit_o), .irq(mark_irq_o), .irq_en(mark_irq_en_i)
);

// File: tb/rot_pos_tracker_bench.sv
module rot_pos_tracker_bench;
  localparam int REV = 2048;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] word_ivl_i = 16'd1;
  logic [10:0] tgt_word_i = '0;
  logic        mark_irq_en_i = 1'b1;
  logic [10:0] pos_o, latency_o;
  logic        index_mark_o, addr_hit_o, mark_irq_o;

  int errors = 0, checks = 0, irq_seen = 0;
  int m_cnt = 0, m_pos = 0, m_lat = 0, m_irq = 0;
  bit m_wrapped = 0, m_behind = 0, live = 0, done = 0;

  always #4 clk = ~clk;  // 125 MHz

  rot_pos_tracker u_rot_pos_tracker (
    .clk_i(clk), .rst_ni(rst_ni), .word_ivl_i(word_ivl_i),
    .tgt_word_i(tgt_word_i), .mark_irq_en_i(mark_irq_en_i),
    .pos_o(pos_o), .index_mark_o(index_mark_o), .addr_hit_o(addr_hit_o),
    .latency_o(latency_o), .mark_irq_o(mark_irq_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference, advanced on every rising edge, compared shortly after.
  always @(posedge clk) begin
    int eff;
    bit adv;
    if (!rst_ni) begin
      m_cnt = 0; m_pos = 0; m_lat = 0; m_irq = 0; m_wrapped = 0; m_behind = 0;
    end else begin
      eff = (word_ivl_i == 0) ? 1 : int'(word_ivl_i);
      adv = (m_cnt + 1 >= eff);
      m_irq = (adv && m_pos == REV - 1 && mark_irq_en_i) ? 1 : 0;
      m_behind = (int'(tgt_word_i) < m_pos);
      m_lat = (int'(tgt_word_i) - m_pos + REV) % REV;
      m_wrapped = adv && m_pos == REV - 1;
      m_cnt = adv ? 0 : m_cnt + 1;
      if (adv) m_pos = (m_pos + 1) % REV;
    end
    live = 1;
    #2;
    check(m_wrapped ? "R1" : (word_ivl_i == 0 ? "R3" : "R2"), int'(pos_o), m_pos);
    check("R4", int'(index_mark_o), (m_pos < 6) ? 1 : 0);
    check("R5", int'(addr_hit_o), (int'(tgt_word_i) == m_pos) ? 1 : 0);
    check(m_behind ? "R7" : "R6", int'(latency_o), m_lat);
    check("R8", int'(mark_irq_o), m_irq);
    if (mark_irq_o) irq_seen++;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int p0;
    cycles(3);
    // R10: reset state
    check("R10", int'(pos_o), 0);
    check("R10", int'(latency_o), 0);
    check("R10", int'(mark_irq_o), 0);
    rst_ni = 1'b1;
    // R8: three revolutions at one cycle per word, enable on
    irq_seen = 0;
    cycles(3 * REV + 4);
    check("R8", irq_seen, 3);
    // R9: enable off for a full revolution
    mark_irq_en_i = 1'b0;
    irq_seen = 0;
    cycles(REV + 4);
    check("R9", irq_seen, 0);
    mark_irq_en_i = 1'b1;
    // R3: zero interval
    word_ivl_i = 16'd0;
    p0 = int'(pos_o);
    cycles(10);
    check("R3", int'(pos_o), (p0 + 10) % REV);
    // R6 R7 R5: interval 5, targets ahead, behind and on the position
    word_ivl_i = 16'd5;
    for (int i = 0; i < 150; i++) begin
      if (i % 4 == 3) tgt_word_i = pos_o;
      else tgt_word_i = 11'((i * 37 + 1000) % REV);
      cycles(3);
    end
    // R7 directed: target just behind the position
    tgt_word_i = pos_o - 11'd7;
    cycles(1);
    check("R7", int'(latency_o), (int'(tgt_word_i) - int'(pos_o) + REV) % REV);
    // R11: long interval, then drop it
    word_ivl_i = 16'd40;
    cycles(20);
    word_ivl_i = 16'd3;
    p0 = int'(pos_o);
    @(posedge clk); #2;
    check("R11", int'(pos_o), (p0 + 1) % REV);
    cycles(30);
    // R10: asynchronous reset in mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R10", int'(pos_o), 0);
    check("R10", int'(latency_o), 0);
    check("R10", int'(mark_irq_o), 0);
    cycles(2);
    rst_ni = 1'b1;
    word_ivl_i = 16'd2;
    cycles(40);
    done = 1;
  end

  initial begin
    int wd = 0;
    while (!done && wd < 200000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", wd);
    end
    #3;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule